// File: doc/BRIEF.md
# Strobe-Decoded Successive-Approximation Converter Controller

This block is the digital control core of a parallel-output successive-approximation converter. An external host drives a single active-low chip-select strobe and a read/convert select level. The block watches the falling edges of the strobe and samples the select level on each one. From these it walks through five phases: idle, acquisition, conversion, result ready and bus drive. It produces the track/hold control, the reference power enable and an active-low end-of-conversion flag. It also drives a 16-bit result word together with its output enable, which is meant for a three-state pad ring.

In the conversion phase an internal engine tests one bit per step, starting at the most significant bit. It presents each trial word to the capacitive DAC on `dac_code` and reads back a single comparator decision. The strobe edge that starts the conversion also latches a power mode. In standby the reference stays powered once the result is ready. In shutdown the reference is switched off at that point.

Top module: `sar_strobe_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `track` is low, `eoc_n` is high, `dout_oe` is low, `dout` is all zeros and `ref_pwr_en` is low.
- R2: In idle, a strobe falling edge with `rd_sel` low raises `ref_pwr_en` and `track` (acquisition). A falling edge with `rd_sel` high leaves `track`, `ref_pwr_en`, `eoc_n` and `dout_oe` unchanged.
- R3: In acquisition, the next strobe falling edge drops `track` and starts conversion. The `rd_sel` level on that edge is latched as the power mode: 1 means shutdown, 0 means standby.
- R4: The conversion tests the bits from the most significant down to the least significant, one bit every `STEP_DIV` clocks. At each step the trial bit is set on `dac_code`. The bit is kept when `cmp_in` is 1 and cleared when it is 0. When the conversion starts, `dac_code` holds only its top bit set. The conversion lasts exactly `DATA_W*STEP_DIV` clocks.
- R5: One clock after the last bit decision, `eoc_n` goes low. At that point `ref_pwr_en` goes low in shutdown mode and stays high in standby mode.
- R6: `dout_oe` stays low and `dout` stays zero through idle, acquisition, conversion and result ready. A strobe falling edge with `rd_sel` high while the result is ready sets `dout_oe` and puts the result on `dout`.
- R7: A strobe rising edge while the bus is driven clears `dout_oe`, zeros `dout`, raises `eoc_n` and returns to idle. The next falling edge with `rd_sel` low starts a new acquisition.
- R8: Strobe falling edges during conversion are ignored: the result and the timing of `eoc_n` are unaffected.
- R9: A strobe falling edge with `rd_sel` low while the result is ready is ignored: `eoc_n` stays low and `dout_oe` stays low.
- R10: Reset, applied with the strobe high in any phase, returns the block to idle with `ref_pwr_en` low. The next falling edge with `rd_sel` low starts acquisition.
- R11: The strobe and select inputs pass through a two-stage synchronizer, so a strobe edge takes effect on the third rising clock edge after it appears at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Asynchronous active-low chip-select strobe |
| rd_sel | input | 1 | Read/convert select level, sampled on each strobe falling edge |
| cmp_in | input | 1 | Comparator decision: 1 when the held input is at or above `dac_code` |
| track | output | 1 | Track/hold control, high while acquiring |
| dac_code | output | DATA_W | Trial word presented to the capacitive DAC |
| eoc_n | output | 1 | Active-low end-of-conversion flag |
| ref_pwr_en | output | 1 | Reference and reference buffer power enable |
| dout_oe | output | 1 | Output enable for the three-state result bus |
| dout | output | DATA_W | Result word, zero when not enabled |

## Verification
The properties assume that `cmp_in` changes only in response to `dac_code`, and that the host holds `rd_sel` steady from before a strobe falling edge until after the synchronizer has captured it. They also assume that reset arrives with the strobe high. The stimulus meets these assumptions by modelling the comparator as a live comparison between a held sample and `dac_code`. It changes `rd_sel` only on the same clock as the strobe edge and keeps both stable for several clocks afterwards. Random samples and random power modes are mixed with stuck-high and stuck-low comparators, stray strobes during conversion and in the ready phase, and a reset issued in the middle of acquisition.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ACQ   = 3'd1,
        PH_CONV  = 3'd2,
        PH_READY = 3'd3,
        PH_DRIVE = 3'd4
    } ctrl_phase_e;

endpackage

// File: rtl/cs_strobe_sync.sv
module cs_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_sel,
    output logic cs_fall,
    output logic cs_rise,
    output logic sel_lvl
);
    typedef struct packed {
        logic [STAGES-1:0] cs_chain;
        logic [STAGES-1:0] sel_chain;
        logic              cs_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.cs_chain[0]  = cs_n;
        sync_d.sel_chain[0] = rd_sel;
        sync_d.cs_prev      = sync_q.cs_chain[STAGES-1];
        for (int i = 1; i < STAGES; i++) begin
            sync_d.cs_chain[i]  = sync_q.cs_chain[i-1];
            sync_d.sel_chain[i] = sync_q.sel_chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q.cs_chain  <= '1;
            sync_q.sel_chain <= '0;
            sync_q.cs_prev   <= 1'b1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cs_fall = sync_q.cs_prev & ~sync_q.cs_chain[STAGES-1];
    assign cs_rise = ~sync_q.cs_prev & sync_q.cs_chain[STAGES-1];
    assign sel_lvl = sync_q.sel_chain[STAGES-1];

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int DATA_W   = 16,
    parameter int STEP_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] code,
    output logic              busy,
    output logic              done
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int DW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] code;
        logic [BW-1:0]     bit_idx;
        logic [DW-1:0]     div;
        logic              busy;
        logic              done;
    } sar_t;

    sar_t sar_d, sar_q;

    always_comb begin
        sar_d      = sar_q;
        sar_d.done = 1'b0;
        if (start) begin
            sar_d.code             = '0;
            sar_d.code[DATA_W-1]   = 1'b1;
            sar_d.bit_idx          = BW'(DATA_W - 1);
            sar_d.div              = '0;
            sar_d.busy             = 1'b1;
        end else if (sar_q.busy) begin
            if (sar_q.div == DW'(STEP_DIV - 1)) begin
                sar_d.div = '0;
                if (!cmp_in) begin
                    sar_d.code[sar_q.bit_idx] = 1'b0;
                end
                if (sar_q.bit_idx == '0) begin
                    sar_d.busy = 1'b0;
                    sar_d.done = 1'b1;
                end else begin
                    sar_d.code[sar_q.bit_idx - 1'b1] = 1'b1;
                    sar_d.bit_idx = sar_q.bit_idx - 1'b1;
                end
            end else begin
                sar_d.div = sar_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q <= '0;
        end else begin
            sar_q <= sar_d;
        end
    end

    assign code = sar_q.code;
    assign busy = sar_q.busy;
    assign done = sar_q.done;

endmodule

// File: rtl/sar_strobe_ctrl.sv
module sar_strobe_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int STEP_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_sel,
    input  logic              cmp_in,
    output logic              track,
    output logic [DATA_W-1:0] dac_code,
    output logic              eoc_n,
    output logic              ref_pwr_en,
    output logic              dout_oe,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        ctrl_phase_e       phase;
        logic              ref_on;
        logic              shut_mode;
        logic [DATA_W-1:0] result;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic cs_fall, cs_rise, sel_lvl;
    logic sar_start, sar_busy, sar_done;
    logic [DATA_W-1:0] sar_code;

    cs_strobe_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rd_sel  (rd_sel),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise),
        .sel_lvl (sel_lvl)
    );

    assign sar_start = (ctrl_q.phase == PH_ACQ) && cs_fall;

    sar_bit_engine #(
        .DATA_W   (DATA_W),
        .STEP_DIV (STEP_DIV)
    ) u_engine (
        .clk    (clk),
        .rst    (rst),
        .start  (sar_start),
        .cmp_in (cmp_in),
        .code   (sar_code),
        .busy   (sar_busy),
        .done   (sar_done)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (cs_fall && !sel_lvl) begin
                    ctrl_d.phase  = PH_ACQ;
                    ctrl_d.ref_on = 1'b1;
                end
            end
            PH_ACQ: begin
                if (cs_fall) begin
                    ctrl_d.phase     = PH_CONV;
                    ctrl_d.shut_mode = sel_lvl;
                end
            end
            PH_CONV: begin
                if (sar_done) begin
                    ctrl_d.phase  = PH_READY;
                    ctrl_d.result = sar_code;
                    if (ctrl_q.shut_mode) begin
                        ctrl_d.ref_on = 1'b0;
                    end
                end
            end
            PH_READY: begin
                if (cs_fall && sel_lvl) begin
                    ctrl_d.phase = PH_DRIVE;
                end
            end
            PH_DRIVE: begin
                if (cs_rise) begin
                    ctrl_d.phase = PH_IDLE;
                end
            end
            default: ctrl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.phase     <= PH_IDLE;
            ctrl_q.ref_on    <= 1'b0;
            ctrl_q.shut_mode <= 1'b0;
            ctrl_q.result    <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign track      = (ctrl_q.phase == PH_ACQ);
    assign eoc_n      = !((ctrl_q.phase == PH_READY) || (ctrl_q.phase == PH_DRIVE));
    assign dout_oe    = (ctrl_q.phase == PH_DRIVE);
    assign dout       = dout_oe ? ctrl_q.result : '0;
    assign ref_pwr_en = ctrl_q.ref_on;
    assign dac_code   = sar_code;

endmodule

// File: rtl/sar_strobe_ctrl_chk.sv
module sar_strobe_ctrl_chk #(
    parameter int DATA_W   = 16,
    parameter int STEP_DIV = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              track,
    input logic              eoc_n,
    input logic              ref_pwr_en,
    input logic              dout_oe,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] dac_code,
    input logic              sar_busy
);
    localparam int CONV_CYC = DATA_W * STEP_DIV;
    localparam int CW       = $clog2(CONV_CYC + 1) + 1;
    localparam logic [DATA_W-1:0] TOP_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (sar_busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    AST_TRACK_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        track |-> ref_pwr_en) else $error("track without reference power"); // R2

    AST_NO_TRACK_AFTER_EOC: assert property (@(posedge clk) disable iff (rst)
        !eoc_n |-> !track) else $error("tracking with result ready"); // R3

    AST_START_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(sar_busy) |-> (dac_code == TOP_ONLY)) else $error("first trial word wrong"); // R4

    AST_CONV_BOUND: assert property (@(posedge clk) disable iff (rst)
        sar_busy |-> (busy_cnt < CW'(CONV_CYC))) else $error("conversion overran"); // R4

    AST_EOC_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(sar_busy) |=> !eoc_n) else $error("eoc late"); // R5

    AST_OE_NEEDS_EOC: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> !eoc_n) else $error("bus driven before result"); // R6

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0)) else $error("dout not zero when disabled"); // R6

    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && $past(dout_oe)) |-> $stable(dout)) else $error("dout moved while driven"); // R6

    AST_EOC_RISE_DROPS_OE: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_n) |-> !dout_oe) else $error("bus left driven"); // R7

endmodule

bind sar_strobe_ctrl sar_strobe_ctrl_chk #(
    .DATA_W   (DATA_W),
    .STEP_DIV (STEP_DIV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .track      (track),
    .eoc_n      (eoc_n),
    .ref_pwr_en (ref_pwr_en),
    .dout_oe    (dout_oe),
    .dout       (dout),
    .dac_code   (dac_code),
    .sar_busy   (sar_busy)
);

// File: tb/test_sar_strobe_ctrl.sv
module test_sar_strobe_ctrl;
    localparam int W        = 16;
    localparam int STEP_DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic rd_sel = 1'b0;
    logic cmp_in;
    logic track, eoc_n, ref_pwr_en, dout_oe;
    logic [W-1:0] dac_code, dout;

    logic [W-1:0] vin = '0;
    int cmp_force = -1;   // -1: live comparator, 0/1: stuck
    int n_checks = 0;
    int n_err = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    always_comb begin
        if (cmp_force == 0)      cmp_in = 1'b0;
        else if (cmp_force == 1) cmp_in = 1'b1;
        else                     cmp_in = (vin >= dac_code);
    end

    sar_strobe_ctrl #(.DATA_W(W), .STEP_DIV(STEP_DIV)) i_sar_strobe_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_sel(rd_sel), .cmp_in(cmp_in),
        .track(track), .dac_code(dac_code), .eoc_n(eoc_n),
        .ref_pwr_en(ref_pwr_en), .dout_oe(dout_oe), .dout(dout)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_err = n_err + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: run hung act=%0d exp=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    function automatic logic [W-1:0] model_code(input logic [W-1:0] v, input int force_mode);
        logic [W-1:0] acc = '0;
        for (int b = W - 1; b >= 0; b--) begin
            logic [W-1:0] trial = acc | (W'(1) << b);
            logic keep = (force_mode == 0) ? 1'b0 : (force_mode == 1) ? 1'b1 : (v >= trial);
            if (keep) acc = trial;
        end
        return acc;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_low(input logic sel);
        @(negedge clk);
        rd_sel = sel;
        cs_n = 1'b0;
        wait_n(5);
    endtask

    task automatic strobe_high;
        @(negedge clk);
        cs_n = 1'b1;
        wait_n(5);
    endtask

    task automatic wait_eoc(output int took);
        took = 0;
        while (eoc_n && took < 400) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic run_cycle(input logic [W-1:0] v, input logic shut, input logic stray);
        int took;
        logic [W-1:0] exp_v;
        vin = v;
        exp_v = model_code(v, cmp_force);
        strobe_low(1'b0);
        chk(track === 1'b1 && ref_pwr_en === 1'b1, "R2 acquire", {14'd0, track, ref_pwr_en}, 16'h3);
        chk(dout_oe === 1'b0 && eoc_n === 1'b1, "R6 quiet in acquire", {14'd0, dout_oe, eoc_n}, 16'h1);
        strobe_high();
        @(negedge clk);
        rd_sel = shut;
        cs_n = 1'b0;
        wait_n(4);
        chk(track === 1'b0 && eoc_n === 1'b1, "R3 hold and convert", {14'd0, track, eoc_n}, 16'h1);
        @(negedge clk);
        cs_n = 1'b1;
        if (stray) begin
            wait_n(3);
            rd_sel = 1'b1;
            cs_n = 1'b0;
            wait_n(4);
            cs_n = 1'b1;
            chk(eoc_n === 1'b1 && dout_oe === 1'b0, "R8 stray strobe in convert", {14'd0, eoc_n, dout_oe}, 16'h2);
        end
        wait_eoc(took);
        chk(eoc_n === 1'b0, "R5 eoc low", {15'd0, eoc_n}, 16'h0);
        chk(ref_pwr_en === !shut, "R5 reference power mode", {15'd0, ref_pwr_en}, {15'd0, !shut});
        chk(dout_oe === 1'b0 && dout === '0, "R6 quiet when ready", dout, 16'h0);
        wait_n(4);
        strobe_low(1'b1);
        chk(dout_oe === 1'b1, "R6 bus enable", {15'd0, dout_oe}, 16'h1);
        chk(dout === exp_v, "R4 result", dout, exp_v);
        strobe_high();
        chk(dout_oe === 1'b0 && dout === '0 && eoc_n === 1'b1, "R7 release", {dout[13:0], dout_oe, eoc_n}, 16'h1);
    endtask

    initial begin
        int took;
        int edge_at;
        void'($urandom(32'h5A17));
        wait_n(3);
        chk(track === 1'b0 && eoc_n === 1'b1 && dout_oe === 1'b0 && ref_pwr_en === 1'b0 && dout === '0,
            "R1 reset state", {12'd0, track, eoc_n, dout_oe, ref_pwr_en}, 16'h4);
        @(negedge clk);
        rst = 1'b0;
        wait_n(2);
        chk(track === 1'b0 && eoc_n === 1'b1 && dout_oe === 1'b0 && ref_pwr_en === 1'b0,
            "R1 after release", {12'd0, track, eoc_n, dout_oe, ref_pwr_en}, 16'h4);

        // R2: strobe with select high in idle is ignored
        strobe_low(1'b1);
        chk(track === 1'b0 && ref_pwr_en === 1'b0 && eoc_n === 1'b1 && dout_oe === 1'b0,
            "R2 ignored strobe", {12'd0, track, ref_pwr_en, eoc_n, dout_oe}, 16'h2);
        strobe_high();

        // R11: edge lands on third rising clock edge
        @(negedge clk);
        rd_sel = 1'b0;
        cs_n = 1'b0;
        edge_at = 0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (track && edge_at == 0) edge_at = k;
        end
        chk(edge_at == 3, "R11 synchronizer latency", W'(edge_at), 16'd3);
        strobe_high();

        // R10: reset mid-acquisition with strobe high
        @(negedge clk);
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(2);
        chk(track === 1'b0 && ref_pwr_en === 1'b0 && eoc_n === 1'b1, "R10 reset to idle",
            {13'd0, track, ref_pwr_en, eoc_n}, 16'h1);

        // directed corners (run_cycle begins with a fresh acquisition: R10 and R7 restart)
        run_cycle(16'h0000, 1'b0, 1'b0);
        run_cycle(16'hFFFF, 1'b1, 1'b0);
        run_cycle(16'h8000, 1'b0, 1'b1);
        run_cycle(16'h7FFF, 1'b1, 1'b1);
        cmp_force = 1;
        run_cycle(16'h1234, 1'b0, 1'b0);
        cmp_force = 0;
        run_cycle(16'h1234, 1'b1, 1'b0);
        cmp_force = -1;

        // R9: strobe with select low when ready is ignored
        vin = 16'hA5C3;
        strobe_low(1'b0);
        strobe_high();
        strobe_low(1'b0);
        strobe_high();
        wait_eoc(took);
        chk(took <= W * STEP_DIV + 8, "R4 conversion length", W'(took), W'(W * STEP_DIV + 8));
        strobe_low(1'b0);
        chk(eoc_n === 1'b0 && dout_oe === 1'b0, "R9 ignored read strobe", {14'd0, eoc_n, dout_oe}, 16'h0);
        strobe_high();
        chk(eoc_n === 1'b0 && dout_oe === 1'b0, "R9 still ready", {14'd0, eoc_n, dout_oe}, 16'h0);
        strobe_low(1'b1);
        chk(dout === model_code(16'hA5C3, -1), "R9 result kept", dout, 16'hA5C3);
        strobe_high();

        // random
        for (int i = 0; i < 40; i++) begin
            run_cycle(W'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule